// File: doc/BRIEF.md
# Banked Interrupt Control Unit

This block collects interrupt requests from several identical banks of 32 sources each and turns them into one request line per bank for the processor. Every source input that is high at a clock edge latches a pending bit in its bank's status register. Software selects which pending bits may raise the bank's request by programming an enable register. It reads the masked pending set from an output status register and clears serviced bits by writing ones to the status register. For each bank the block also presents the index of the highest-numbered pending and enabled source, with a valid flag, so the handler can service that source without scanning the register.

All registers are reached over a plain 32-bit register bus: a byte address, a write strobe, write data and combinational read data. The five per-bank registers repeat at a fixed stride, so bank n occupies the window starting at n times the stride. Apart from the status, enable and mode storage, the block holds no state. The request and index outputs follow the registers without delay.

The register decode is purely combinational, so the house-style state machine does not apply. The block has no sequencing beyond the per-bit latch.

Top module: `icu_banked_top`

## Requirements
- R1: After reset every status, enable and mode register of every bank reads 0, every request output is 0 and every index valid flag is 0.
- R2: A source input that is high at a rising clock edge sets its status bit, which stays set after the source returns low (status at bank offset 0x00).
- R3: A write to the status register clears each status bit whose write-data bit is 1 and leaves every bit written with 0 unchanged.
- R4: When a source is high in the same cycle as a write that clears its status bit, the bit stays set.
- R5: The enable register at bank offset 0x08 reads back exactly what was written, so a single bit can be changed by read-modify-write without disturbing the rest.
- R6: The output status register at bank offset 0x10 reads status AND enable, and writes to it change nothing.
- R7: The raw register at bank offset 0x18 returns the current, unlatched source inputs of the bank, and writes to it change nothing.
- R8: The mode register at bank offset 0x20 is 32-bit read/write storage whose contents affect no other register or output.
- R9: Bank n's registers start at byte address n*0x28, and an access to one bank never changes another bank.
- R10: A bank's request output is 1 exactly when its output status is non-zero.
- R11: A bank's 5-bit index output gives the highest-numbered set bit of its output status with the valid flag 1. When the output status is zero, the valid flag is 0 and the index is 0.
- R12: Addresses inside a bank window that match no register, and addresses past the last bank, read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, applied at the next rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| src_in | input | 160 | Source inputs, bank n in bits n*32+31..n*32 |
| irq_req | output | 5 | Per-bank request line toward the processor |
| irq_idx | output | 25 | Per-bank highest pending enabled index, bank n in bits n*5+4..n*5 |
| irq_vld | output | 5 | Per-bank index valid flag |

## Verification
The encoder sees a single low bit (0), a single top bit (31), two separated bits where only the lower one is enabled, and then both enabled. This shows that it picks the most significant bit and not the least, and that the enable mask is applied before encoding. Source pulses of one cycle show the latch apart from a level pass-through. A source held during a clearing write shows whether set or clear has priority. Writes to the same offset in a different bank, to the read-only offsets, and to unmapped holes show whether the decode confines each write to its one register.

// File: rtl/icu_pkg.sv
package icu_pkg;

    // Register offsets inside one bank window; software depends on them.
    localparam int unsigned OFS_STAT  = 32'h00;
    localparam int unsigned OFS_EN    = 32'h08;
    localparam int unsigned OFS_OSTAT = 32'h10;
    localparam int unsigned OFS_RAW   = 32'h18;
    localparam int unsigned OFS_MODE  = 32'h20;

    typedef enum logic [2:0] {
        REG_STAT,
        REG_EN,
        REG_OSTAT,
        REG_RAW,
        REG_MODE,
        REG_NONE
    } reg_sel_e;

endpackage

// File: rtl/icu_addr_dec.sv
module icu_addr_dec
    import icu_pkg::*;
#(
    parameter int unsigned NB     = 5,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned STRIDE = 40
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NB-1:0]     bank_hit,
    output reg_sel_e          sel
);

    logic [NB-1:0][ADDR_W-1:0] local_ofs;
    logic [ADDR_W-1:0]         ofs;

    for (genvar n = 0; n < NB; n++) begin : g_win
        localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(n * STRIDE);
        localparam logic [ADDR_W:0] HI = (ADDR_W+1)'((n + 1) * STRIDE);
        assign bank_hit[n]  = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
        assign local_ofs[n] = addr - LO[ADDR_W-1:0];
    end

    always_comb begin
        ofs = '0;
        for (int n = 0; n < NB; n++) begin
            if (bank_hit[n]) ofs = local_ofs[n];
        end
    end

    always_comb begin
        sel = REG_NONE;
        if (|bank_hit) begin
            case (ofs)
                ADDR_W'(OFS_STAT):  sel = REG_STAT;
                ADDR_W'(OFS_EN):    sel = REG_EN;
                ADDR_W'(OFS_OSTAT): sel = REG_OSTAT;
                ADDR_W'(OFS_RAW):   sel = REG_RAW;
                ADDR_W'(OFS_MODE):  sel = REG_MODE;
                default:            sel = REG_NONE;
            endcase
        end
    end

endmodule

// File: rtl/icu_bank.sv
module icu_bank
    import icu_pkg::*;
#(
    parameter int unsigned SRC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src,
    input  logic             hit,
    input  logic             wr,
    input  reg_sel_e         sel,
    input  logic [SRC_W-1:0] wdata,
    output logic [SRC_W-1:0] rdata,
    output logic [SRC_W-1:0] stat,
    output logic [SRC_W-1:0] en,
    output logic [SRC_W-1:0] ostat,
    output logic             req
);

    logic [SRC_W-1:0] mode_q;
    logic [SRC_W-1:0] clr_mask;
    logic             wr_here;

    assign wr_here  = hit && wr;
    assign clr_mask = (wr_here && sel == REG_STAT) ? wdata : '0;

    // Pending latch: a source set in the same cycle beats a clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~clr_mask) | src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          en <= '0;
        else if (wr_here && sel == REG_EN)   en <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          mode_q <= '0;
        else if (wr_here && sel == REG_MODE) mode_q <= wdata;
    end

    assign ostat = stat & en;
    assign req   = |ostat;

    always_comb begin
        rdata = '0;
        if (hit) begin
            case (sel)
                REG_STAT:  rdata = stat;
                REG_EN:    rdata = en;
                REG_OSTAT: rdata = ostat;
                REG_RAW:   rdata = src;
                REG_MODE:  rdata = mode_q;
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/icu_msb_enc.sv
module icu_msb_enc #(
    parameter int unsigned W     = 32,
    parameter int unsigned IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             vld
);

    always_comb begin
        idx = '0;
        vld = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
                vld = 1'b1;
            end
        end
    end

endmodule

// File: rtl/icu_banked_top.sv
module icu_banked_top
    import icu_pkg::*;
#(
    parameter int unsigned NUM_BANKS   = 5,
    parameter int unsigned SRC_W       = 32,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned BANK_STRIDE = 40,
    localparam int unsigned IDX_W      = $clog2(SRC_W)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic [SRC_W-1:0]           bus_wdata,
    output logic [SRC_W-1:0]           bus_rdata,
    input  logic [NUM_BANKS*SRC_W-1:0] src_in,
    output logic [NUM_BANKS-1:0]       irq_req,
    output logic [NUM_BANKS*IDX_W-1:0] irq_idx,
    output logic [NUM_BANKS-1:0]       irq_vld
);

    logic [NUM_BANKS-1:0]            bank_hit;
    reg_sel_e                        sel;
    logic [NUM_BANKS-1:0][SRC_W-1:0] bank_rdata;
    logic [NUM_BANKS-1:0][SRC_W-1:0] bank_stat;
    logic [NUM_BANKS-1:0][SRC_W-1:0] bank_en;
    logic [NUM_BANKS-1:0][SRC_W-1:0] bank_ostat;
    logic [NUM_BANKS-1:0][SRC_W-1:0] bank_src;

    icu_addr_dec #(
        .NB     (NUM_BANKS),
        .ADDR_W (ADDR_W),
        .STRIDE (BANK_STRIDE)
    ) dec_i (
        .addr     (bus_addr),
        .bank_hit (bank_hit),
        .sel      (sel)
    );

    for (genvar n = 0; n < NUM_BANKS; n++) begin : g_bank
        assign bank_src[n] = src_in[n*SRC_W +: SRC_W];

        icu_bank #(
            .SRC_W (SRC_W)
        ) bank_i (
            .clk   (clk),
            .rst_n (rst_n),
            .src   (bank_src[n]),
            .hit   (bank_hit[n]),
            .wr    (bus_wr),
            .sel   (sel),
            .wdata (bus_wdata),
            .rdata (bank_rdata[n]),
            .stat  (bank_stat[n]),
            .en    (bank_en[n]),
            .ostat (bank_ostat[n]),
            .req   (irq_req[n])
        );

        icu_msb_enc #(
            .W     (SRC_W),
            .IDX_W (IDX_W)
        ) enc_i (
            .vec (bank_ostat[n]),
            .idx (irq_idx[n*IDX_W +: IDX_W]),
            .vld (irq_vld[n])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int n = 0; n < NUM_BANKS; n++) begin
            bus_rdata = bus_rdata | bank_rdata[n];
        end
    end

endmodule

// File: rtl/icu_banked_chk.sv
module icu_banked_chk #(
    parameter int unsigned NB    = 5,
    parameter int unsigned SRC_W = 32,
    parameter int unsigned IDX_W = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_wr,
    input logic [NB-1:0]           irq_req,
    input logic [NB*IDX_W-1:0]     irq_idx,
    input logic [NB-1:0]           irq_vld,
    input logic [NB-1:0][SRC_W-1:0] bank_stat,
    input logic [NB-1:0][SRC_W-1:0] bank_en,
    input logic [NB-1:0][SRC_W-1:0] bank_ostat,
    input logic [NB-1:0][SRC_W-1:0] bank_src
);

    for (genvar n = 0; n < NB; n++) begin : g_chk
        // R2 R4
        src_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((bank_stat[n] & $past(bank_src[n])) == $past(bank_src[n])));

        // R2
        no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((bank_stat[n] & ~$past(bank_stat[n]) & ~$past(bank_src[n])) == '0));

        // R3
        stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !bus_wr |=> ((bank_stat[n] & $past(bank_stat[n])) == $past(bank_stat[n])));

        // R5
        en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !bus_wr |=> $stable(bank_en[n]));

        // R10
        req_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[n] == irq_vld[n]);

        // R11
        msb_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_vld[n] |-> ((bank_ostat[n] >> irq_idx[n*IDX_W +: IDX_W]) == SRC_W'(1)));

        // R11
        idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_vld[n] |-> (irq_idx[n*IDX_W +: IDX_W] == '0));
    end

endmodule

bind icu_banked_top icu_banked_chk #(
    .NB    (NUM_BANKS),
    .SRC_W (SRC_W),
    .IDX_W (IDX_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .irq_req    (irq_req),
    .irq_idx    (irq_idx),
    .irq_vld    (irq_vld),
    .bank_stat  (bank_stat),
    .bank_en    (bank_en),
    .bank_ostat (bank_ostat),
    .bank_src   (bank_src)
);

// File: tb/icu_banked_tb.sv
`timescale 1ns/1ps
module icu_banked_top_tb_top;

    localparam int NB = 5;
    localparam int SW = 32;
    localparam int IW = 5;
    localparam int STR = 40;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic [SW-1:0]   bus_wdata = '0;
    logic [SW-1:0]   bus_rdata;
    logic [NB*SW-1:0] src_in = '0;
    logic [NB-1:0]   irq_req;
    logic [NB*IW-1:0] irq_idx;
    logic [NB-1:0]   irq_vld;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    icu_banked_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_in    (src_in),
        .irq_req   (irq_req),
        .irq_idx   (irq_idx),
        .irq_vld   (irq_vld)
    );

    function automatic logic [7:0] ra(int bank, int ofs);
        return 8'(bank * STR + ofs);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #2;
        d = bus_rdata;
    endtask

    task automatic pulse_src(int bank, logic [31:0] v);
        @(negedge clk);
        src_in[bank*SW +: SW] = v;
        @(negedge clk);
        src_in[bank*SW +: SW] = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int b = 0; b < NB; b++) begin
            rd(ra(b, 'h00), d); check("R1 stat", d, 0);
            rd(ra(b, 'h08), d); check("R1 en", d, 0);
            rd(ra(b, 'h20), d); check("R1 mode", d, 0);
        end
        check("R1 req", 32'(irq_req), 0);
        check("R1 vld", 32'(irq_vld), 0);
    endtask

    task automatic t_latch();
        logic [31:0] d;
        @(negedge clk);
        src_in[0 +: SW] = 32'h0000_0101;
        rd(ra(0, 'h18), d); check("R7 raw live", d, 32'h0000_0101);
        @(negedge clk);
        src_in[0 +: SW] = '0;
        rd(ra(0, 'h00), d); check("R2 latched", d, 32'h0000_0101);
        rd(ra(0, 'h18), d); check("R7 raw low", d, 0);
        wr(ra(0, 'h18), 32'hFFFF_FFFF);
        rd(ra(0, 'h18), d); check("R7 raw write ignored", d, 0);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(ra(0, 'h00), 32'h1);
        rd(ra(0, 'h00), d); check("R3 clear one", d, 32'h100);
        wr(ra(0, 'h00), 32'h0);
        rd(ra(0, 'h00), d); check("R3 zero write", d, 32'h100);
    endtask

    task automatic t_setwins();
        logic [31:0] d;
        @(negedge clk);
        src_in[8] = 1'b1;
        bus_addr = ra(0, 'h00); bus_wdata = 32'h100; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; src_in[8] = 1'b0;
        rd(ra(0, 'h00), d); check("R4 set wins", d, 32'h100);
        wr(ra(0, 'h00), 32'h100);
        rd(ra(0, 'h00), d); check("R3 cleared", d, 0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(ra(0, 'h08), 32'h8000_0000);
        rd(ra(0, 'h08), d); check("R5 readback", d, 32'h8000_0000);
        wr(ra(0, 'h08), d | 32'h8);
        rd(ra(0, 'h08), d); check("R5 rmw set", d, 32'h8000_0008);
        wr(ra(0, 'h08), d & ~32'h8000_0000);
        rd(ra(0, 'h08), d); check("R5 rmw clear", d, 32'h8);
        wr(ra(0, 'h08), 0);
    endtask

    task automatic t_ostat_enc();
        logic [31:0] d;
        pulse_src(2, 32'h0010_0008);
        rd(ra(2, 'h10), d); check("R6 masked zero", d, 0);
        check("R10 req low", 32'(irq_req), 0);
        wr(ra(2, 'h08), 32'h8);
        rd(ra(2, 'h10), d); check("R6 ostat", d, 32'h8);
        check("R10 req bank2", 32'(irq_req), 32'h4);
        check("R11 idx 3", 32'(irq_idx[2*IW +: IW]), 3);
        check("R11 vld", 32'(irq_vld), 32'h4);
        wr(ra(2, 'h08), 32'h0010_0008);
        check("R11 idx msb 20", 32'(irq_idx[2*IW +: IW]), 20);
        wr(ra(2, 'h10), 32'hFFFF_FFFF);
        rd(ra(2, 'h10), d); check("R6 write ignored", d, 32'h0010_0008);
        rd(ra(2, 'h00), d); check("R6 stat intact", d, 32'h0010_0008);
        pulse_src(2, 32'h8000_0001);
        wr(ra(2, 'h08), 32'h8000_0001);
        check("R11 idx 31", 32'(irq_idx[2*IW +: IW]), 31);
        wr(ra(2, 'h08), 32'h1);
        check("R11 idx 0", 32'(irq_idx[2*IW +: IW]), 0);
        check("R11 vld idx0", 32'(irq_vld[2]), 1);
        wr(ra(2, 'h00), 32'hFFFF_FFFF);
        check("R10 req cleared", 32'(irq_req), 0);
        check("R11 vld cleared", 32'(irq_vld), 0);
        check("R11 idx cleared", 32'(irq_idx[2*IW +: IW]), 0);
        wr(ra(2, 'h08), 0);
    endtask

    task automatic t_mode();
        logic [31:0] d;
        wr(ra(1, 'h20), 32'hA5A5_5A5A);
        rd(ra(1, 'h20), d); check("R8 mode", d, 32'hA5A5_5A5A);
        rd(ra(1, 'h08), d); check("R8 en untouched", d, 0);
        rd(ra(1, 'h00), d); check("R8 stat untouched", d, 0);
        check("R8 no req", 32'(irq_req), 0);
    endtask

    task automatic t_banks();
        logic [31:0] d;
        wr(ra(4, 'h08), 32'h20);
        rd(ra(4, 'h08), d); check("R9 bank4 en", d, 32'h20);
        for (int b = 0; b < 4; b++) begin
            rd(ra(b, 'h08), d); check("R9 other en", d, 0);
        end
        pulse_src(3, 32'h20);
        rd(ra(3, 'h00), d); check("R9 bank3 stat", d, 32'h20);
        rd(ra(4, 'h00), d); check("R9 bank4 stat", d, 0);
        check("R9 no req", 32'(irq_req), 0);
        wr(ra(3, 'h00), 32'hFFFF_FFFF);
        wr(ra(4, 'h08), 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, d); check("R12 hole", d, 0);
        rd(ra(0, 'h08), d); check("R12 en safe", d, 0);
        rd(ra(0, 'h00), d); check("R12 stat safe", d, 0);
        wr(8'hC8, 32'hFFFF_FFFF);
        rd(8'hC8, d); check("R12 past end", d, 0);
        rd(8'h24, d); check("R12 tail hole", d, 0);
        rd(ra(4, 'h08), d); check("R12 last bank en", d, 0);
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_w1c();
        t_setwins();
        t_enable();
        t_ostat_enc();
        t_mode();
        t_banks();
        t_unmapped();
        repeat (2) @(negedge clk);
        finish_up();
    end

endmodule